// File: doc/BRIEF.md
# Latched Prioritized Interrupt Controller

This block collects interrupt events for a small 8-bit microcontroller core. Six sources feed it: an external capacitor pin event, general-purpose I/O, two USB endpoint events (endpoint 0 and endpoint 1), and two timer ticks at 128 µs and 1.024 ms. Each event pulse sets a pending latch for its source. An 8-bit enable register decides which pending latches may raise a request. The core reads and writes that register through its simple I/O port.

At each instruction boundary, the highest-priority source that is both pending and enabled drives a request and a 3-bit vector index to the core. When the core accepts the request, the block clears the whole enable register and clears the latch of the winning source only. Software can then set the enables again inside the service routine, so interrupts can nest. The block sets no limit on nesting depth.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The enable register is read and written at I/O address 0x20. A read at any other address returns 0, and a write to any other address leaves the register unchanged.
- R2: Enable bit positions are: 1 = 128 µs timer, 2 = 1.024 ms timer, 3 = endpoint 0, 4 = endpoint 1, 6 = GPIO, 7 = external capacitor pin. The `evt_i` bit for each source uses the same position. Writing 1 to a position enables that source.
- R3: Bits 5 and 0 of the enable register always read 0, and writes to them are ignored.
- R4: Reset clears the enable register and every pending latch.
- R5: An event sets its source's pending latch on the next clock edge. The latch stays set until that source is serviced or reset occurs. A pending source that is disabled keeps its latch.
- R6: `irq_req` is high only while `insn_done` is high and at least one source is both pending and enabled. While `irq_req` is low, `irq_vec` is 0.
- R7: Priority runs from highest to lowest as 128 µs timer, 1.024 ms timer, endpoint 0, endpoint 1, GPIO, external pin. The `irq_vec` codes for these sources are 0 to 5 in that order.
- R8: An accepted acknowledge (`irq_ack` high while `irq_req` is high) clears the whole enable register on that clock edge. It wins over an enable write in the same cycle.
- R9: An accepted acknowledge clears only the winning source's pending latch.
- R10: If a source's event arrives in the same cycle that its latch is cleared by acknowledge, the latch stays set.
- R11: `irq_ack` while `irq_req` is low has no effect on the enables or the latches.
- R12: After an acknowledge, software may write the enables again, and any enabled pending source then requests again. This allows nesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O port address |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational) |
| evt_i | input | 8 | Source event pulses, one per enable bit position |
| insn_done | input | 1 | Current instruction completes this cycle |
| irq_ack | input | 1 | Core accepts the presented request |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 3 | Index of the winning source |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is an accepted acknowledge and a software write to the enable register. The bench provokes this by driving a write of a new enable value in the same cycle as an accepted acknowledge, then reading the register back and expecting zero. The second pair is a new event for the source being serviced and the clearing of its latch. The bench pulses that source's event during its acknowledge, then re-enables the source and expects the same vector again at the next instruction boundary.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter logic [7:0] EN_ADDR = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] io_addr,
  input  logic       io_wr,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  input  logic [7:0] evt_i,
  input  logic       insn_done,
  input  logic       irq_ack,
  output logic       irq_req,
  output logic [2:0] irq_vec
);
  localparam logic [7:0] LIVE = 8'hDE;
  localparam int NSRC = 6;

  function automatic logic [2:0] pos_of(input logic [2:0] v);
    case (v)
      3'd0:    pos_of = 3'd1;
      3'd1:    pos_of = 3'd2;
      3'd2:    pos_of = 3'd3;
      3'd3:    pos_of = 3'd4;
      3'd4:    pos_of = 3'd6;
      default: pos_of = 3'd7;
    endcase
  endfunction

  logic [7:0] en_q, pend_q, hot;
  logic [2:0] win_vec, win_pos;
  logic       any, take, sel;

  assign hot = pend_q & en_q;

  always_comb begin
    any     = 1'b0;
    win_vec = 3'd0;
    for (int v = NSRC - 1; v >= 0; v--) begin
      if (hot[pos_of(3'(v))]) begin
        any     = 1'b1;
        win_vec = 3'(v);
      end
    end
  end

  assign win_pos  = pos_of(win_vec);
  assign irq_req  = insn_done & any;
  assign irq_vec  = irq_req ? win_vec : 3'd0;
  assign take     = irq_ack & irq_req;
  assign sel      = (io_addr == EN_ADDR);
  assign io_rdata = sel ? en_q : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 8'h00;
      pend_q <= 8'h00;
    end else begin
      if (take)
        en_q <= 8'h00;
      else if (io_wr && sel)
        en_q <= io_wdata & LIVE;
      pend_q <= (pend_q & ~(take ? (8'b1 << win_pos) : 8'h00)) | (evt_i & LIVE);
    end
  end

  p_ack_clears_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (en_q == 8'h00));

  p_pend_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  p_serviced_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !evt_i[win_pos]) |=> !pend_q[$past(win_pos)]);

  p_new_evt_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && evt_i[win_pos]) |=> pend_q[$past(win_pos)]);

  p_req_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (insn_done && en_q[pos_of(irq_vec)] && pend_q[pos_of(irq_vec)]));

  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_rdata & ~LIVE) == 8'h00));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] io_addr = 8'h20, io_wdata = 8'h00, evt_i = 8'h00;
  logic       io_wr = 1'b0, insn_done = 1'b0, irq_ack = 1'b0;
  logic [7:0] io_rdata;
  logic       irq_req;
  logic [2:0] irq_vec;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .evt_i(evt_i),
    .insn_done(insn_done), .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  // {evt, wr, wdata, insn, ack, exp_req, exp_vec, exp_en_after}
  localparam int N = 27;
  localparam logic [30:0] TBL [N] = '{
    {8'h02, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00}, // R5 latch while disabled
    {8'h00, 1'b1, 8'h02, 1'b1, 1'b0, 1'b0, 3'd0, 8'h02}, // R2 enable 128us
    {8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 3'd0, 8'h02}, // R6 boundary request
    {8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, 8'h02}, // R6 no boundary
    {8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 3'd0, 8'h00}, // R8 ack
    {8'hD8, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 3'd0, 8'hDE}, // R3 reserved masked
    {8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 3'd2, 8'h00}, // R7 ep0 wins
    {8'h00, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 3'd0, 8'hDE}, // R12 re-enable
    {8'h10, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 3'd3, 8'h00}, // R10 ep1 event during clear
    {8'h00, 1'b1, 8'h10, 1'b0, 1'b0, 1'b0, 3'd0, 8'h10}, // R12
    {8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 3'd3, 8'h00}, // R10 ep1 still pending
    {8'h00, 1'b1, 8'h80, 1'b0, 1'b0, 1'b0, 3'd0, 8'h80}, // R2 cext only
    {8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 3'd5, 8'h80}, // R7 cext
    {8'h00, 1'b1, 8'h40, 1'b1, 1'b1, 1'b1, 3'd5, 8'h00}, // R8 ack beats write
    {8'h00, 1'b1, 8'h21, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00}, // R3 reserved ignored
    {8'h00, 1'b1, 8'h40, 1'b0, 1'b0, 1'b0, 3'd0, 8'h40}, // R9 gpio kept
    {8'h04, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 3'd4, 8'h00}, // R7 gpio
    {8'h00, 1'b1, 8'h06, 1'b1, 1'b0, 1'b0, 3'd0, 8'h06}, // R6
    {8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 3'd1, 8'h06}, // R7 1ms
    {8'h02, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 3'd1, 8'h06}, // R5 set at edge
    {8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 3'd0, 8'h06}, // R7 128us above 1ms
    {8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0, 8'h06}, // R11 stray ack
    {8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 3'd0, 8'h00}, // R9
    {8'h00, 1'b1, 8'h04, 1'b0, 1'b0, 1'b0, 3'd0, 8'h04}, // R12 nest
    {8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 3'd1, 8'h00}, // R9 1ms kept
    {8'h00, 1'b1, 8'hDE, 1'b1, 1'b0, 1'b0, 3'd0, 8'hDE}, // R1 write
    {8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 8'hDE}  // R9 all serviced
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    evt_i = 8'h00; io_wr = 1'b0; insn_done = 1'b0; irq_ack = 1'b0; io_addr = 8'h20;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R4 rdata", io_rdata, 8'h00);
    chk("R4 req", irq_req, 0);
    @(negedge clk); rst_n = 1'b1;
    chk("R4 en after reset", io_rdata, 8'h00);

    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      {evt_i, io_wr, io_wdata, insn_done, irq_ack} = TBL[i][30:12];
      #1;
      chk($sformatf("R6/R7 req row %0d", i), irq_req, TBL[i][11]);
      chk($sformatf("R7 vec row %0d", i), irq_vec, TBL[i][10:8]);
      @(posedge clk); #1;
      chk($sformatf("R8/R1 en row %0d", i), io_rdata, TBL[i][7:0]);
    end
    idle();

    // R1: other address
    @(negedge clk); io_addr = 8'h21;
    #1 chk("R1 other addr read", io_rdata, 8'h00);
    io_wr = 1'b1; io_wdata = 8'h00;
    @(posedge clk); #1;
    io_wr = 1'b0; io_addr = 8'h20;
    #1 chk("R1 other addr write ignored", io_rdata, 8'hDE);

    // R4: reset drops pending latches
    @(negedge clk); evt_i = 8'hDE;
    @(negedge clk); evt_i = 8'h00; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R4 en cleared", io_rdata, 8'h00);
    io_wr = 1'b1; io_wdata = 8'hFF;
    @(negedge clk); io_wr = 1'b0; insn_done = 1'b1;
    #1 chk("R4 pending cleared", irq_req, 0);
    chk("R2 enable readback", io_rdata, 8'hDE);
    idle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule